// File: doc/BRIEF.md
# Read-After-Write Dependence and Operand Bypass Controller

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it compares the two source register numbers of the instruction in decode with the destination numbers of the instructions held in the execute, memory and writeback pipeline registers. For each source it drives a bypass-mux select that names the closest older instruction that will write that register. When no such instruction exists, the select picks the register file.

It also covers the one dependence that bypassing cannot hide. A load sitting in execute has no data yet, so when the decode instruction needs the result as an operand, the block raises a stall that freezes fetch and decode. In the same cycle it raises a bubble that turns the execute slot into a no-op.

There is one exception to that stall. When a store needs the loaded value only as the data it writes, the store goes ahead without stalling. A registered select then feeds the load result from writeback straight into the store's memory stage. A parameter removes the writeback bypass path for register files that write in the first half of the cycle and read in the second.

Top module: `raw_bypass_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it is released, `mem_store_fwd` is 0.
- R2: Register number 0 is never a dependence source. A source of 0 always gets select 00, and a producer whose destination is 0 causes neither a forward nor a stall.
- R3: A source that matches the execute-stage destination, with `ex_wen` set, gets select 01.
- R4: When several stages match the same source, the youngest producer wins: execute (01) before memory (10) before writeback (11).
- R5: A source that matches only the memory-stage destination gets 10. One that matches only the writeback destination gets 11 when `WB_BYPASS` is 1.
- R6: A stage whose write enable is clear is never selected and never causes a stall. With no match at all, the select is 00.
- R7: `load_stall` and `id_bubble` are both 1 in the same cycle when `ex_is_load` and `ex_wen` are set and a used source of the decode instruction equals a nonzero `ex_rd`.
- R8: A source whose use flag (`id_rs_used` or `id_rt_used`) is 0 never causes a load stall.
- R9: When the decode instruction is a store (`id_is_store`) and only its data source `id_rt` matches the loading execute stage, there is no stall. A match on its base source `id_rs` still stalls.
- R10: `mem_store_fwd` is 1 in the cycle after one in which `ex_is_store` is set, `mem_is_load` and `mem_wen` are set, and `ex_rt` equals a nonzero `mem_rd`.
- R11: `mem_store_fwd` is 0 in the cycle after any cycle in which those conditions do not all hold.
- R12: With `WB_BYPASS` set to 0, a writeback-only match gives select 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register (store data for stores) |
| id_rs_used | input | 1 | Decode instruction reads `id_rs` |
| id_rt_used | input | 1 | Decode instruction reads `id_rt` |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rd | input | REG_W | Destination register in execute |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_is_store | input | 1 | Execute-stage instruction is a store |
| ex_rt | input | REG_W | Store data register of the execute-stage instruction |
| mem_rd | input | REG_W | Destination register in memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Destination register in writeback |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_rs_sel | output | 2 | Bypass select for `id_rs` (00 file, 01 EX, 10 MEM, 11 WB) |
| fwd_rt_sel | output | 2 | Bypass select for `id_rt`, same encoding |
| load_stall | output | 1 | Freeze fetch and decode |
| id_bubble | output | 1 | Replace the instruction entering execute with a no-op |
| mem_store_fwd | output | 1 | Feed the writeback load data into the memory-stage store data |

## Verification
The two forward selects, the stall and the bubble are combinational. They are due in the same cycle as the stage fields that cause them, so the bench drives the fields after a falling edge and samples one time unit later, before the next rising edge. The memory-stage store bypass passes through one register. Its cause is driven in one cycle, and the bench samples one time unit after the following rising edge. It then samples again one cycle later, which confirms that the bypass lasts exactly one cycle. A second instance built without the writeback path is driven with the same stimulus to show that the path is removed.

// File: rtl/raw_bypass_pkg.sv
// Shared types for the bypass controller.
// Assumes a two-bit select on every operand bypass mux.
package raw_bypass_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_EX  = 2'b01,
        SEL_MEM = 2'b10,
        SEL_WB  = 2'b11
    } fwd_sel_e;

    localparam int NUM_PROD = 3;   // producer stages: EX, MEM, WB in that order
    localparam int IDX_EX   = 0;
    localparam int IDX_MEM  = 1;
    localparam int IDX_WB   = 2;
endpackage

// File: rtl/hzd_src_match.sv
// Compares one source register number against every producer stage.
// A stage hits when its write enable is set, its destination is nonzero,
// and its destination equals the source. Assumes register 0 is hard-wired.
module hzd_src_match
    import raw_bypass_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0]    src,
    input  logic [REG_W-1:0]    prod_rd  [NUM_PROD],
    input  logic [NUM_PROD-1:0] prod_wen,
    output logic [NUM_PROD-1:0] hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    for (genvar s = 0; s < NUM_PROD; s++) begin : g_stage
        // per-stage equality with write-enable and zero-register gating
        always_comb begin
            hit[s] = prod_wen[s] && (prod_rd[s] != ZERO_REG) && (prod_rd[s] == src);
        end
    end
endmodule

// File: rtl/hzd_fwd_pick.sv
// Turns per-stage hits into a bypass select, youngest producer first.
// When WB_BYPASS is 0 the register file is assumed to write before it reads,
// so the writeback hit is dropped.
module hzd_fwd_pick
    import raw_bypass_pkg::*;
#(
    parameter bit WB_BYPASS = 1'b1
) (
    input  logic [NUM_PROD-1:0] hit,
    output fwd_sel_e            sel
);
    logic wb_hit;

    if (WB_BYPASS) begin : g_wb_on
        assign wb_hit = hit[IDX_WB];
    end else begin : g_wb_off
        assign wb_hit = 1'b0;
    end

    // priority: EX over MEM over WB over register file
    always_comb begin
        if (hit[IDX_EX])       sel = SEL_EX;
        else if (hit[IDX_MEM]) sel = SEL_MEM;
        else if (wb_hit)       sel = SEL_WB;
        else                   sel = SEL_RF;
    end
endmodule

// File: rtl/hzd_load_use.sv
// Detects a decode instruction that needs the result of a load now in execute.
// A store whose data operand alone matches is exempt: its data is patched in
// the memory stage instead. Assumes the stages below decode always advance.
module hzd_load_use (
    input  logic ex_load_wr,    // EX holds a load that writes a register
    input  logic rs_hit_ex,     // first source matches the EX destination
    input  logic rt_hit_ex,     // second source matches the EX destination
    input  logic rs_used,
    input  logic rt_used,
    input  logic id_is_store,
    output logic stall,
    output logic bubble
);
    logic rs_need;
    logic rt_need;

    // an operand needs the value now unless it is a store's data operand
    always_comb begin
        rs_need = rs_used && rs_hit_ex;
        rt_need = rt_used && rt_hit_ex && !id_is_store;
    end

    // freeze above, no-op below, in the same cycle
    always_comb begin
        stall  = ex_load_wr && (rs_need || rt_need);
        bubble = stall;
    end
endmodule

// File: rtl/hzd_store_fwd.sv
// Registers the decision to feed a writeback load result into the data of
// the store that follows it. The store is in EX and the load in MEM when the
// decision is taken; both advance one stage by the next edge.
module hzd_store_fwd #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_is_store,
    input  logic [REG_W-1:0] ex_rt,
    input  logic             mem_is_load,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] mem_rd,
    output logic             fwd
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;
    logic fwd_next;

    // store data operand produced by the load one stage ahead
    always_comb begin
        fwd_next = ex_is_store && mem_is_load && mem_wen &&
                   (mem_rd != ZERO_REG) && (mem_rd == ex_rt);
    end

    // data-stationary control: select travels with the store into MEM
    always_ff @(posedge clk) begin
        if (!rst_n) fwd <= 1'b0;
        else        fwd <= fwd_next;
    end
endmodule

// File: rtl/raw_bypass_ctrl.sv
// Top of the dependence and bypass controller. Compares both decode sources
// with the EX, MEM and WB destinations, drives the bypass selects, the
// load-use stall and bubble, and the memory-stage store data bypass.
// Assumes in-order single issue and writebacks only in the last stage.
module raw_bypass_ctrl
    import raw_bypass_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter bit WB_BYPASS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_rs_used,
    input  logic             id_rt_used,
    input  logic             id_is_store,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_is_load,
    input  logic             ex_is_store,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output logic [1:0]       fwd_rs_sel,
    output logic [1:0]       fwd_rt_sel,
    output logic             load_stall,
    output logic             id_bubble,
    output logic             mem_store_fwd
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0]    prod_rd  [NUM_PROD];
    logic [NUM_PROD-1:0] prod_wen;
    logic [REG_W-1:0]    src      [NUM_SRC];
    logic [NUM_PROD-1:0] hit      [NUM_SRC];
    fwd_sel_e            sel      [NUM_SRC];

    // gather the producer stages in age order, youngest first
    always_comb begin
        prod_rd[IDX_EX]   = ex_rd;
        prod_rd[IDX_MEM]  = mem_rd;
        prod_rd[IDX_WB]   = wb_rd;
        prod_wen[IDX_EX]  = ex_wen;
        prod_wen[IDX_MEM] = mem_wen;
        prod_wen[IDX_WB]  = wb_wen;
        src[0]            = id_rs;
        src[1]            = id_rt;
    end

    for (genvar o = 0; o < NUM_SRC; o++) begin : g_opnd
        hzd_src_match #(.REG_W(REG_W)) u_match (
            .src      (src[o]),
            .prod_rd  (prod_rd),
            .prod_wen (prod_wen),
            .hit      (hit[o])
        );
        hzd_fwd_pick #(.WB_BYPASS(WB_BYPASS)) u_pick (
            .hit (hit[o]),
            .sel (sel[o])
        );
    end

    // drive the select ports
    always_comb begin
        fwd_rs_sel = sel[0];
        fwd_rt_sel = sel[1];
    end

    hzd_load_use u_load_use (
        .ex_load_wr  (ex_is_load && ex_wen),
        .rs_hit_ex   (hit[0][IDX_EX]),
        .rt_hit_ex   (hit[1][IDX_EX]),
        .rs_used     (id_rs_used),
        .rt_used     (id_rt_used),
        .id_is_store (id_is_store),
        .stall       (load_stall),
        .bubble      (id_bubble)
    );

    hzd_store_fwd #(.REG_W(REG_W)) u_store_fwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex_is_store (ex_is_store),
        .ex_rt       (ex_rt),
        .mem_is_load (mem_is_load),
        .mem_wen     (mem_wen),
        .mem_rd      (mem_rd),
        .fwd         (mem_store_fwd)
    );
endmodule

// File: rtl/raw_bypass_chk.sv
// Temporal checks on the bypass controller ports, bound into every instance.
module raw_bypass_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_rs,
    input logic [REG_W-1:0] id_rt,
    input logic             id_rs_used,
    input logic             id_rt_used,
    input logic             id_is_store,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_wen,
    input logic             ex_is_load,
    input logic             ex_is_store,
    input logic [REG_W-1:0] ex_rt,
    input logic [REG_W-1:0] mem_rd,
    input logic             mem_wen,
    input logic             mem_is_load,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_wen,
    input logic [1:0]       fwd_rs_sel,
    input logic [1:0]       fwd_rt_sel,
    input logic             load_stall,
    input logic             id_bubble,
    input logic             mem_store_fwd
);
    assert_zero_rs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0) |-> (fwd_rs_sel == 2'b00));
    assert_zero_rt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rt == '0) |-> (fwd_rt_sel == 2'b00));
    assert_ex_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wen && ex_rd != '0 && id_rs == ex_rd) |-> (fwd_rs_sel == 2'b01));
    assert_no_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wen && !mem_wen && !wb_wen) |-> (fwd_rs_sel == 2'b00 && fwd_rt_sel == 2'b00 && !load_stall));
    assert_stall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_stall |-> (ex_is_load && ex_wen && id_bubble));
    assert_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_rs_used && !id_rt_used) |-> !load_stall);
    assert_store_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_store && mem_is_load && mem_wen && mem_rd != '0 && ex_rt == mem_rd)
        |=> mem_store_fwd);
    assert_store_fwd_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_is_store && mem_is_load && mem_wen) |=> !mem_store_fwd);
endmodule

bind raw_bypass_ctrl raw_bypass_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_raw_bypass_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_raw_bypass_ctrl;
    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REG_W-1:0] id_rs, id_rt, ex_rd, ex_rt, mem_rd, wb_rd;
    logic             id_rs_used, id_rt_used, id_is_store;
    logic             ex_wen, ex_is_load, ex_is_store, mem_wen, mem_is_load, wb_wen;
    logic [1:0]       fwd_rs_sel, fwd_rt_sel, wt_rs_sel, wt_rt_sel;
    logic             load_stall, id_bubble, mem_store_fwd;
    logic             wt_stall, wt_bubble, wt_store_fwd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    raw_bypass_ctrl #(.REG_W(REG_W), .WB_BYPASS(1'b1)) dut (
        .clk, .rst_n, .id_rs, .id_rt, .id_rs_used, .id_rt_used, .id_is_store,
        .ex_rd, .ex_wen, .ex_is_load, .ex_is_store, .ex_rt,
        .mem_rd, .mem_wen, .mem_is_load, .wb_rd, .wb_wen,
        .fwd_rs_sel, .fwd_rt_sel, .load_stall, .id_bubble, .mem_store_fwd
    );

    raw_bypass_ctrl #(.REG_W(REG_W), .WB_BYPASS(1'b0)) dut_wt (
        .clk, .rst_n, .id_rs, .id_rt, .id_rs_used, .id_rt_used, .id_is_store,
        .ex_rd, .ex_wen, .ex_is_load, .ex_is_store, .ex_rt,
        .mem_rd, .mem_wen, .mem_is_load, .wb_rd, .wb_wen,
        .fwd_rs_sel(wt_rs_sel), .fwd_rt_sel(wt_rt_sel), .load_stall(wt_stall),
        .id_bubble(wt_bubble), .mem_store_fwd(wt_store_fwd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        id_rs = '0; id_rt = '0; id_rs_used = 1'b1; id_rt_used = 1'b1; id_is_store = 1'b0;
        ex_rd = '0; ex_wen = 1'b0; ex_is_load = 1'b0; ex_is_store = 1'b0; ex_rt = '0;
        mem_rd = '0; mem_wen = 1'b0; mem_is_load = 1'b0; wb_rd = '0; wb_wen = 1'b0;
    endtask

    // combinational results are due in the same cycle: drive after negedge, sample 1 later
    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        idle();
        ex_is_store = 1'b1; ex_rt = 5'd7; mem_is_load = 1'b1; mem_wen = 1'b1; mem_rd = 5'd7;
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", "store_fwd in reset", int'(mem_store_fwd), 0);
        @(negedge clk);
        idle();
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "store_fwd after release", int'(mem_store_fwd), 0);
    endtask

    task automatic t_zero_reg();
        settle();
        idle();
        ex_wen = 1'b1; ex_rd = 5'd0; ex_is_load = 1'b1; mem_wen = 1'b1; mem_rd = 5'd0;
        id_rs = 5'd0; id_rt = 5'd0;
        #1;
        chk("R2", "rs sel on r0", int'(fwd_rs_sel), 0);
        chk("R2", "rt sel on r0", int'(fwd_rt_sel), 0);
        chk("R2", "stall on r0", int'(load_stall), 0);
    endtask

    task automatic t_single_stage();
        settle();
        idle();
        ex_wen = 1'b1; ex_rd = 5'd3; id_rs = 5'd3; id_rt = 5'd4;
        #1;
        chk("R3", "rs from EX", int'(fwd_rs_sel), 1);
        chk("R6", "rt unmatched", int'(fwd_rt_sel), 0);
        idle();
        mem_wen = 1'b1; mem_rd = 5'd9; id_rt = 5'd9;
        #1;
        chk("R5", "rt from MEM", int'(fwd_rt_sel), 2);
        idle();
        wb_wen = 1'b1; wb_rd = 5'd12; id_rs = 5'd12;
        #1;
        chk("R5", "rs from WB", int'(fwd_rs_sel), 3);
        chk("R12", "rs from WB without path", int'(wt_rs_sel), 0);
    endtask

    task automatic t_priority();
        settle();
        idle();
        ex_wen = 1'b1; ex_rd = 5'd6; mem_wen = 1'b1; mem_rd = 5'd6; wb_wen = 1'b1; wb_rd = 5'd6;
        id_rs = 5'd6; id_rt = 5'd6;
        #1;
        chk("R4", "EX beats MEM and WB", int'(fwd_rs_sel), 1);
        ex_wen = 1'b0;
        #1;
        chk("R4", "MEM beats WB", int'(fwd_rt_sel), 2);
        chk("R4", "MEM on no-WB instance", int'(wt_rt_sel), 2);
    endtask

    task automatic t_wen_clear();
        settle();
        idle();
        ex_rd = 5'd8; ex_is_load = 1'b1; mem_rd = 5'd8; wb_rd = 5'd8;
        id_rs = 5'd8; id_rt = 5'd8;
        #1;
        chk("R6", "rs with no enables", int'(fwd_rs_sel), 0);
        chk("R6", "rt with no enables", int'(fwd_rt_sel), 0);
        chk("R6", "no stall without ex_wen", int'(load_stall), 0);
    endtask

    task automatic t_load_use();
        settle();
        idle();
        ex_wen = 1'b1; ex_is_load = 1'b1; ex_rd = 5'd10; id_rs = 5'd1; id_rt = 5'd10;
        #1;
        chk("R7", "stall on rt use", int'(load_stall), 1);
        chk("R7", "bubble on rt use", int'(id_bubble), 1);
        id_rt = 5'd2;
        #1;
        chk("R7", "no stall without match", int'(load_stall), 0);
        ex_is_load = 1'b0; id_rs = 5'd10;
        #1;
        chk("R7", "no stall for non-load", int'(load_stall), 0);
    endtask

    task automatic t_unused();
        settle();
        idle();
        ex_wen = 1'b1; ex_is_load = 1'b1; ex_rd = 5'd11; id_rs = 5'd11; id_rt = 5'd11;
        id_rs_used = 1'b0; id_rt_used = 1'b0;
        #1;
        chk("R8", "unused operands do not stall", int'(load_stall), 0);
        id_rt_used = 1'b1;
        #1;
        chk("R8", "used rt stalls", int'(load_stall), 1);
    endtask

    task automatic t_store_data();
        settle();
        idle();
        id_is_store = 1'b1; ex_wen = 1'b1; ex_is_load = 1'b1; ex_rd = 5'd14;
        id_rs = 5'd2; id_rt = 5'd14;
        #1;
        chk("R9", "store data match no stall", int'(load_stall), 0);
        chk("R9", "store data match no bubble", int'(id_bubble), 0);
        id_rs = 5'd14; id_rt = 5'd3;
        #1;
        chk("R9", "store base match stalls", int'(load_stall), 1);
    endtask

    task automatic t_store_fwd();
        @(negedge clk);
        idle();
        ex_is_store = 1'b1; ex_rt = 5'd21; mem_is_load = 1'b1; mem_wen = 1'b1; mem_rd = 5'd21;
        @(posedge clk); #1;
        chk("R10", "store bypass one cycle later", int'(mem_store_fwd), 1);
        chk("R10", "store bypass no-WB instance", int'(wt_store_fwd), 1);
        @(negedge clk);
        idle();
        @(posedge clk); #1;
        chk("R11", "store bypass drops", int'(mem_store_fwd), 0);
    endtask

    task automatic t_store_fwd_neg();
        @(negedge clk);
        idle();
        ex_is_store = 1'b1; ex_rt = 5'd21; mem_is_load = 1'b0; mem_wen = 1'b1; mem_rd = 5'd21;
        @(posedge clk); #1;
        chk("R11", "no bypass when MEM is not a load", int'(mem_store_fwd), 0);
        @(negedge clk);
        mem_is_load = 1'b1; mem_rd = 5'd22;
        @(posedge clk); #1;
        chk("R11", "no bypass on register mismatch", int'(mem_store_fwd), 0);
        @(negedge clk);
        mem_rd = 5'd0; ex_rt = 5'd0;
        @(posedge clk); #1;
        chk("R2", "no bypass on r0", int'(mem_store_fwd), 0);
        @(negedge clk);
        idle();
    endtask

    initial begin
        t_reset();
        t_zero_reg();
        t_single_stage();
        t_priority();
        t_wen_clear();
        t_load_use();
        t_unused();
        t_store_data();
        t_store_fwd();
        t_store_fwd_neg();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule